// File: doc/BRIEF.md
# Staggered Bank Refresh Scheduler

This block decides when an SDRAM array needs refreshing. It then steps through the installed banks, requesting one refresh command per bank. A free-running interval counter, or a one-cycle test pulse, raises a pending trigger. While the scheduler is idle, a pending trigger starts a sequence. The sequence asks the command sequencer for a refresh of bank 0, waits for a grant, and moves to the next installed bank. Between consecutive commands it leaves a programmable gap, so the current draw of the refresh is spread over time.

The interval is a 9-bit field in units of 64 core clocks, and zero switches periodic refresh off. The gap between banks is counted in memory clock enables, not core clocks, so it follows the SDRAM clock whatever ratio that clock has to the core. Triggers that arrive while a sequence is running, or while one is already pending, collapse into a single pending trigger. They are not queued.

Top module: `refresh_stagger_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, refReq, busy and refBank are all 0.
- R2: With intervalField = N (N ≠ 0), the interval counter raises a trigger every N×64 core clocks and restarts at each trigger. A trigger seen while idle makes busy and refReq rise two cycles after the counter's terminal cycle. When every sequence completes within the interval, successive sequences therefore start exactly N×64 cycles apart.
- R3: With intervalField = 0, the interval counter is held at zero and raises no trigger, so without a test pulse refReq stays low.
- R4: A sequence starts at bank 0 and moves up by one bank for each granted command. It ends after bank bankCount−1. A bankCount of 0 counts as one bank and any value above 4 counts as four, so refBank never names a bank that is not installed.
- R5: Once raised, refReq stays high and refBank stays unchanged until grant is sampled high together with refReq.
- R6: staggerSel sets the gap after a granted command that is not the last: 2'b00 = 0, 2'b01 = 1, 2'b10 = 2, 2'b11 = 4 memory clock enables. The enables counted are those in the cycles after the grant cycle and before the next request. A gap of 0 requests the next bank in the cycle after the grant.
- R7: During a gap, only cycles with memClkEn high advance the gap, so refReq stays low for as long as memClkEn stays low.
- R8: A one-cycle testRefresh pulse sets a pending trigger regardless of intervalField. If the scheduler is idle, refReq rises two cycles after the pulse cycle.
- R9: Any number of triggers arriving while a sequence is in progress produce exactly one further sequence after it.
- R10: busy rises with the first refReq of a sequence. busy and refReq both fall in the cycle after the grant of the last installed bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memClkEn | input | 1 | One core-clock pulse per memory clock; counts stagger gaps |
| intervalField | input | 9 | Refresh interval in units of 64 core clocks; 0 = off |
| staggerSel | input | 2 | Gap between bank commands: 0, 1, 2 or 4 memory clocks |
| testRefresh | input | 1 | Pulse that forces a refresh trigger |
| bankCount | input | 3 | Number of installed banks (0 treated as 1, above 4 as 4) |
| grant | input | 1 | Command sequencer accepts the current refresh command |
| refReq | output | 1 | Refresh command wanted for bank refBank |
| refBank | output | 2 | Bank that the current refresh command targets |
| busy | output | 1 | A refresh sequence is in progress |

## Verification
The assertions assume that bankCount does not change while busy is high. The bench therefore changes bankCount only after a drain period in which the interval is off and grant is held high, so every sequence has finished first. The assertions also assume that staggerSel is 2'b00 whenever only one bank is installed, and the stimulus forces that combination. Grants, memory clock enables and test pulses are otherwise random. A cycle-level model built from the requirements is compared against the outputs every cycle. A separate monitor counts the enables in each gap.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  localparam int GAP_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic seqStart;   // begin a sequence at bank 0, consume pending trigger
    logic cmdDone;    // current bank command granted
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic pendReq;
    logic lastBank;
    logic noGap;
    logic gapDone;
  } dpStatus_t;

  function automatic logic [GAP_W-1:0] decodeStagger(input logic [1:0] sel);
    return (sel == 2'b11) ? GAP_W'(4) : GAP_W'(sel);
  endfunction

endpackage

// File: rtl/refsched_datapath.sv
module refsched_datapath
  import refsched_pkg::*;
#(
  parameter int NUM_BANKS      = 4,
  parameter int INTERVAL_W     = 9,
  parameter int INTERVAL_SHIFT = 6,
  localparam int BANK_W  = $clog2(NUM_BANKS),
  localparam int COUNT_W = $clog2(NUM_BANKS + 1),
  localparam int CNT_W   = INTERVAL_W + INTERVAL_SHIFT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  memClkEn,
  input  logic [INTERVAL_W-1:0] intervalField,
  input  logic [1:0]            staggerSel,
  input  logic                  testRefresh,
  input  logic [COUNT_W-1:0]    bankCount,
  input  ctrlStrobe_t           strobe,
  output dpStatus_t             status,
  output logic [BANK_W-1:0]     bankSel
);

  // interval counter
  logic [CNT_W-1:0] intCnt;
  logic [CNT_W-1:0] intLimit;
  logic             intervalOn;
  logic             expire;
  logic             pendReg;

  assign intervalOn = |intervalField;
  assign intLimit   = {intervalField, {INTERVAL_SHIFT{1'b0}}} - CNT_W'(1);
  assign expire     = intervalOn && (intCnt >= intLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intCnt <= '0;
    end else if (!intervalOn || expire) begin
      intCnt <= '0;
    end else begin
      intCnt <= intCnt + CNT_W'(1);
    end
  end

  // pending trigger: merges, never queues
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg <= 1'b0;
    end else begin
      pendReg <= (pendReg && !strobe.seqStart) || expire || testRefresh;
    end
  end

  // installed bank range
  logic [BANK_W-1:0] effLast;
  always_comb begin
    if (bankCount == '0) begin
      effLast = '0;
    end else if (bankCount >= COUNT_W'(NUM_BANKS)) begin
      effLast = BANK_W'(NUM_BANKS - 1);
    end else begin
      effLast = BANK_W'(bankCount - COUNT_W'(1));
    end
  end

  logic lastBank;
  assign lastBank = (bankSel >= effLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankSel <= '0;
    end else if (strobe.seqStart) begin
      bankSel <= '0;
    end else if (strobe.cmdDone && !lastBank) begin
      bankSel <= bankSel + BANK_W'(1);
    end
  end

  // stagger gap counter, counted in memory clock enables
  logic [GAP_W-1:0] gapCnt;
  logic [GAP_W-1:0] gapLoad;
  assign gapLoad = decodeStagger(staggerSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strobe.cmdDone && !lastBank) begin
      gapCnt <= gapLoad;
    end else if (gapCnt != '0 && memClkEn) begin
      gapCnt <= gapCnt - GAP_W'(1);
    end
  end

  assign status.pendReq  = pendReg;
  assign status.lastBank = lastBank;
  assign status.noGap    = (gapLoad == '0);
  assign status.gapDone  = memClkEn && (gapCnt == GAP_W'(1));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (intervalOn && $stable(intervalField)) |-> (intCnt <= intLimit)); // R2
  AST_OFF_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rstN)
    (intervalField == '0) |=> (intCnt == '0)); // R3

endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        grant,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        refReq,
  output logic        busy
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext       = state;
    strobe.seqStart = 1'b0;
    strobe.cmdDone  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (status.pendReq) begin
          strobe.seqStart = 1'b1;
          stateNext       = ST_REQ;
        end
      end
      ST_REQ: begin
        if (grant) begin
          strobe.cmdDone = 1'b1;
          if (status.lastBank) begin
            stateNext = ST_IDLE;
          end else if (status.noGap) begin
            stateNext = ST_REQ;
          end else begin
            stateNext = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (status.gapDone) begin
          stateNext = ST_REQ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign refReq = (state == ST_REQ);
  assign busy   = (state != ST_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !grant) |=> refReq); // R5
  AST_START_FROM_PEND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(status.pendReq)); // R8

endmodule

// File: rtl/refresh_stagger_sched.sv
module refresh_stagger_sched
  import refsched_pkg::*;
#(
  parameter int NUM_BANKS      = 4,
  parameter int INTERVAL_W     = 9,
  parameter int INTERVAL_SHIFT = 6,
  localparam int BANK_W  = $clog2(NUM_BANKS),
  localparam int COUNT_W = $clog2(NUM_BANKS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  memClkEn,
  input  logic [INTERVAL_W-1:0] intervalField,
  input  logic [1:0]            staggerSel,
  input  logic                  testRefresh,
  input  logic [COUNT_W-1:0]    bankCount,
  input  logic                  grant,
  output logic                  refReq,
  output logic [BANK_W-1:0]     refBank,
  output logic                  busy
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  refsched_datapath #(
    .NUM_BANKS      (NUM_BANKS),
    .INTERVAL_W     (INTERVAL_W),
    .INTERVAL_SHIFT (INTERVAL_SHIFT)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .memClkEn      (memClkEn),
    .intervalField (intervalField),
    .staggerSel    (staggerSel),
    .testRefresh   (testRefresh),
    .bankCount     (bankCount),
    .strobe        (strobe),
    .status        (status),
    .bankSel       (refBank)
  );

  refsched_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .grant  (grant),
    .status (status),
    .strobe (strobe),
    .refReq (refReq),
    .busy   (busy)
  );

  AST_FIRST_BANK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (refReq && refBank == '0)); // R4
  AST_BANK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && grant) |=> (!refReq || refBank == BANK_W'($past(refBank) + 1'b1))); // R4
  AST_BANK_INSTALLED: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> ((bankCount == '0) ? (refBank == '0) : (COUNT_W'(refBank) < bankCount))); // R4
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !grant) |=> $stable(refBank)); // R5
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !refReq && !memClkEn) |=> !refReq); // R7
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(refReq && grant)); // R10

endmodule

// File: tb/refresh_stagger_sched_tb.sv
module refresh_stagger_sched_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       memClkEn = 1'b0;
  logic [8:0] intervalField = '0;
  logic [1:0] staggerSel = '0;
  logic       testRefresh = 1'b0;
  logic [2:0] bankCount = 3'd4;
  logic       grant = 1'b0;
  logic       refReq;
  logic [1:0] refBank;
  logic       busy;

  always #2 clk = ~clk; // 250 MHz

  refresh_stagger_sched u_dut (
    .clk(clk), .rstN(rstN), .memClkEn(memClkEn), .intervalField(intervalField),
    .staggerSel(staggerSel), .testRefresh(testRefresh), .bankCount(bankCount),
    .grant(grant), .refReq(refReq), .refBank(refBank), .busy(busy)
  );

  int nChecks = 0;
  int nErrors = 0;
  int cyc = 0;

  function automatic int staggerGap(input logic [1:0] sel);
    return (sel == 2'b11) ? 4 : int'(sel);
  endfunction

  function automatic int effLastOf(input logic [2:0] cnt);
    if (cnt == 0) return 0;
    if (cnt >= 4) return 3;
    return int'(cnt) - 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // cycle-level reference model built from the requirements
  int   mCnt;
  logic mPend;
  int   mState; // 0 idle, 1 request, 2 gap
  int   mBank;
  int   mGap;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= 0; mPend <= 1'b0; mState <= 0; mBank <= 0; mGap <= 0;
    end else begin
      int lim;
      logic trig, start, acc, last, gd;
      lim   = int'(intervalField) * 64 - 1;
      trig  = (intervalField != 0) && (mCnt >= lim);
      last  = mBank >= effLastOf(bankCount);
      start = (mState == 0) && mPend;
      acc   = (mState == 1) && grant;
      gd    = memClkEn && (mGap == 1);
      mCnt  <= (intervalField == 0 || trig) ? 0 : mCnt + 1;
      mPend <= (mPend && !start) || trig || testRefresh;
      case (mState)
        0: if (start) begin mState <= 1; mBank <= 0; end
        1: if (acc) begin
             if (last) mState <= 0;
             else begin
               mBank  <= mBank + 1;
               mState <= (staggerGap(staggerSel) == 0) ? 1 : 2;
             end
           end
        default: if (gd) mState <= 1;
      endcase
      if (acc && !last) mGap <= staggerGap(staggerSel);
      else if (mGap != 0 && memClkEn) mGap <= mGap - 1;
    end
  end

  // monitors
  logic gapActive = 1'b0;
  int   gapCount = 0;
  int   gapExp = 0;
  logic prevBusy = 1'b0;
  int   lastRise = -1;
  logic trackPeriod = 1'b0;
  int   expPeriod = 0;
  int   busyRises = 0;
  int   reqCycles = 0;
  int   maxBank = 0;

  task automatic step(input logic g, input logic m, input logic t);
    @(negedge clk);
    cyc++;
    chk("R10", int'(busy), int'(mState != 0));
    if (mState == 2 || (mState == 0 && mBusyPrev()))
      chk("R6", int'(refReq), int'(mState == 1));
    else
      chk("R2", int'(refReq), int'(mState == 1));
    if (refReq && mState == 1) chk("R4", int'(refBank), mBank);
    if (busy && !prevBusy) begin
      busyRises++;
      if (trackPeriod && lastRise >= 0) chk("R2", cyc - lastRise, expPeriod);
      lastRise = cyc;
    end
    prevBusy = busy;
    if (refReq) begin
      reqCycles++;
      if (int'(refBank) > maxBank) maxBank = int'(refBank);
    end
    grant = g; memClkEn = m; testRefresh = t;
    // gap monitor: enables counted after the grant cycle, before the next request
    if (gapActive) begin
      if (refReq) begin
        chk("R6", gapCount, gapExp);
        gapActive = 1'b0;
      end else if (m) begin
        gapCount++;
      end
    end
    if (refReq && g && int'(refBank) < effLastOf(bankCount)) begin
      gapActive = 1'b1;
      gapCount  = 0;
      gapExp    = staggerGap(staggerSel);
    end
  endtask

  function automatic logic mBusyPrev();
    return prevBusy;
  endfunction

  task automatic drain();
    intervalField = '0;
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    chk("R1", int'(refReq), 0);
    chk("R1", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", int'(refReq), 0);
    chk("R1", int'(busy), 0);
    chk("R1", int'(refBank), 0);

    // R3: interval off, no trigger
    reqCycles = 0;
    for (int i = 0; i < 1000; i++) step(1'($urandom % 2), 1'($urandom % 2), 1'b0);
    chk("R3", reqCycles, 0);

    // R8: test pulse with interval off
    bankCount = 3'd4; staggerSel = 2'b00;
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    chk("R8", int'(refReq), 1);
    chk("R8", int'(refBank), 0);
    drain();

    // R2 period with four banks, no gap, prompt grants; R4 order
    intervalField = 9'd2; trackPeriod = 1'b1; expPeriod = 128; lastRise = -1;
    busyRises = 0; maxBank = 0;
    for (int i = 0; i < 600; i++) step(1'b1, 1'b1, 1'b0);
    trackPeriod = 1'b0;
    chk("R2", busyRises, 4);
    chk("R4", maxBank, 3);
    drain();

    // R4: two banks installed, then zero treated as one
    bankCount = 3'd2; maxBank = 0;
    step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0);
    chk("R4", maxBank, 1);
    bankCount = 3'd0; maxBank = 0; reqCycles = 0;
    step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0);
    chk("R4", maxBank, 0);
    chk("R4", reqCycles, 1);
    bankCount = 3'd4;
    drain();

    // R5: request held without grant across several intervals
    intervalField = 9'd1;
    for (int i = 0; i < 250; i++) step(1'b0, 1'b1, 1'b0);
    chk("R5", int'(refReq), 1);
    chk("R5", int'(refBank), 0);
    // R9: merged triggers give exactly one further sequence
    intervalField = '0; busyRises = 0;
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b0);
    chk("R9", busyRises, 1);
    chk("R10", int'(busy), 0);
    drain();

    // R7: gap frozen while memory clock enable is low
    staggerSel = 2'b01;
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'b0);
    chk("R7", int'(refReq), 0);
    chk("R7", int'(busy), 1);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R7", int'(refReq), 1);
    chk("R7", int'(refBank), 1);
    drain();

    // constrained random phases
    for (int p = 0; p < 20; p++) begin
      bankCount = 3'($urandom % 8);
      staggerSel = (effLastOf(bankCount) == 0) ? 2'b00 : 2'($urandom % 4);
      intervalField = 9'(1 + $urandom % 3);
      for (int i = 0; i < 400; i++)
        step(1'(($urandom % 4) != 0), 1'(($urandom % 3) == 0), 1'(($urandom % 200) == 0));
      drain();
    end

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

endmodule